// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block holds the 16-bit stack pointer of a small processor core and produces the data-memory addresses for every stack access. The pointer is kept as two byte-wide registers, a low half and a high half. Software reaches them through the I/O space, where each half can be read and written independently. Both halves reset to a top-of-RAM address that is set by a parameter.

The core drives one of four operation strobes: single-byte push, single-byte pop, call/interrupt entry and return. The stack grows toward lower addresses. A push stores at the current pointer and then steps down by one. A pop steps up by one and reads at the new position. A call stores the two return-address bytes and steps down by two. A return reads them back and steps up by two.

In the same cycle the block presents two byte addresses for the memory port: a first and a second access. The memory, the return-address data path and the interrupt logic all sit outside the block.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is held, both halves read back the bytes of the TOP_ADDR parameter (low byte on `io_rdata_lo`, high byte on `io_rdata_hi`). This holds whatever the strobes and write enables are doing.
- R2: A push takes effect on the next clock edge and lowers the pointer by one. During the push cycle, `stk_addr_a` and `stk_addr_b` both equal the current pointer.
- R3: A pop takes effect on the next clock edge and raises the pointer by one. During the pop cycle, `stk_addr_a` and `stk_addr_b` both equal the current pointer plus one.
- R4: A call/interrupt entry lowers the pointer by two. During that cycle, `stk_addr_a` equals the pointer (the low return byte goes there) and `stk_addr_b` equals the pointer minus one (the high return byte goes there).
- R5: A return raises the pointer by two. During that cycle, `stk_addr_a` equals the pointer plus one (the high byte is read there) and `stk_addr_b` equals the pointer plus two (the low byte is read there).
- R6: All pointer arithmetic wraps modulo 2^16. A pop at 0xFFFF gives 0x0000, a push at 0x0000 gives 0xFFFF, and a call at 0x0001 gives 0xFFFF.
- R7: When `io_wr_lo` or `io_wr_hi` is high, `io_wdata` is loaded into that half on the next edge, and a half that is not written keeps its value.
- R8: If any I/O write occurs in a cycle, every stack strobe in that cycle is ignored. The pointer then changes only through the write, and both stack addresses equal the current pointer.
- R9: When several strobes are high together, only one of them takes effect. The order of precedence is call, then return, then push, then pop.
- R10: With no strobe and no write, the pointer holds its value and both stack addresses equal it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr_lo | input | 1 | I/O write enable, low half |
| io_wr_hi | input | 1 | I/O write enable, high half |
| io_wdata | input | 8 | I/O write data |
| io_rdata_lo | output | 8 | Current low half |
| io_rdata_hi | output | 8 | Current high half |
| op_push | input | 1 | Single-byte push strobe |
| op_pop | input | 1 | Single-byte pop strobe |
| op_call | input | 1 | Call / interrupt entry strobe |
| op_ret | input | 1 | Return strobe |
| stk_addr_a | output | 16 | First stack access address this cycle |
| stk_addr_b | output | 16 | Second stack access address this cycle |

## Verification
The bench builds the unit with 8-bit halves and a top-of-RAM value of 0x08FF. Because this value is not symmetric, a half swapped at reset, or a reset value taken from the wrong byte, gives a wrong read-back. The wrap corners are out of reach when stepping down from the reset value alone, so the bench uses byte writes to place the pointer at 0xFFFF and 0x0001, and then steps across the 16-bit boundary in both directions. Combined strobes and writes that arrive in the same cycle as an operation exercise the precedence rule and the override rule.

// File: rtl/stkp_pkg.sv
package stkp_pkg;
   typedef enum logic [2:0] {
      SOP_IDLE,
      SOP_PUSH,
      SOP_POP,
      SOP_CALL,
      SOP_RET
   } stk_op_e;
endpackage

// File: rtl/stkp_opdec.sv
module stkp_opdec
   import stkp_pkg::*;
(
   input  logic    push_i,
   input  logic    pop_i,
   input  logic    call_i,
   input  logic    ret_i,
   input  logic    io_busy_i,
   output stk_op_e op_o
);
   // fixed precedence; any register write cancels the stack operation
   always_comb begin
      if (io_busy_i)   op_o = SOP_IDLE;
      else if (call_i) op_o = SOP_CALL;
      else if (ret_i)  op_o = SOP_RET;
      else if (push_i) op_o = SOP_PUSH;
      else if (pop_i)  op_o = SOP_POP;
      else             op_o = SOP_IDLE;
   end
endmodule

// File: rtl/stkp_addr_gen.sv
module stkp_addr_gen
   import stkp_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  stk_op_e           op_i,
   input  logic [ADDR_W-1:0] sp_i,
   output logic [ADDR_W-1:0] addr_a_o,
   output logic [ADDR_W-1:0] addr_b_o,
   output logic [ADDR_W-1:0] sp_next_o
);
   localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

   logic [ADDR_W-1:0] up1, up2, dn1, dn2;

   assign up1 = sp_i + ONE;
   assign up2 = sp_i + TWO;
   assign dn1 = sp_i - ONE;
   assign dn2 = sp_i - TWO;

   always_comb begin
      addr_a_o  = sp_i;
      addr_b_o  = sp_i;
      sp_next_o = sp_i;
      unique case (op_i)
         SOP_PUSH: sp_next_o = dn1;
         SOP_POP: begin
            addr_a_o  = up1;
            addr_b_o  = up1;
            sp_next_o = up1;
         end
         SOP_CALL: begin
            addr_b_o  = dn1;
            sp_next_o = dn2;
         end
         SOP_RET: begin
            addr_a_o  = up1;
            addr_b_o  = up2;
            sp_next_o = up2;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/stkp_byte_reg.sv
module stkp_byte_reg #(
   parameter int unsigned           BYTE_W  = 8,
   parameter logic [BYTE_W-1:0]     RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   input  logic              upd_en_i,
   input  logic [BYTE_W-1:0] upd_val_i,
   output logic [BYTE_W-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o <= RST_VAL;
      else if (wr_en_i)  q_o <= wr_data_i;
      else if (upd_en_i) q_o <= upd_val_i;
   end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
   import stkp_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned TOP_ADDR = 32'h0000_04FF,
   parameter int unsigned MIN_TOP  = 32'h0000_0100
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  io_wr_lo,
   input  logic                  io_wr_hi,
   input  logic [BYTE_W-1:0]     io_wdata,
   output logic [BYTE_W-1:0]     io_rdata_lo,
   output logic [BYTE_W-1:0]     io_rdata_hi,
   input  logic                  op_push,
   input  logic                  op_pop,
   input  logic                  op_call,
   input  logic                  op_ret,
   output logic [2*BYTE_W-1:0]   stk_addr_a,
   output logic [2*BYTE_W-1:0]   stk_addr_b
);
   localparam int unsigned        N_HALF = 2;
   localparam int unsigned        ADDR_W = N_HALF * BYTE_W;
   localparam logic [ADDR_W-1:0]  TOP_V  = ADDR_W'(TOP_ADDR);

   if (BYTE_W < 2 || BYTE_W > 16) begin : g_bad_width
      $error("stack_ptr_unit: BYTE_W out of range");
   end
   if (TOP_ADDR >= (32'h1 << ADDR_W)) begin : g_bad_top
      $error("stack_ptr_unit: TOP_ADDR does not fit the pointer");
   end
   if (TOP_ADDR <= MIN_TOP) begin : g_low_top
      $error("stack_ptr_unit: TOP_ADDR must lie above MIN_TOP");
   end

   stk_op_e             op;
   logic [ADDR_W-1:0]   sp_q;
   logic [ADDR_W-1:0]   sp_next;
   logic [N_HALF-1:0]   wr_vec;

   assign wr_vec = {io_wr_hi, io_wr_lo};

   stkp_opdec u_dec (
      .push_i    (op_push),
      .pop_i     (op_pop),
      .call_i    (op_call),
      .ret_i     (op_ret),
      .io_busy_i (|wr_vec),
      .op_o      (op)
   );

   stkp_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
      .op_i      (op),
      .sp_i      (sp_q),
      .addr_a_o  (stk_addr_a),
      .addr_b_o  (stk_addr_b),
      .sp_next_o (sp_next)
   );

   for (genvar h = 0; h < N_HALF; h++) begin : g_half
      stkp_byte_reg #(
         .BYTE_W  (BYTE_W),
         .RST_VAL (TOP_V[h*BYTE_W +: BYTE_W])
      ) u_reg (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en_i   (wr_vec[h]),
         .wr_data_i (io_wdata),
         .upd_en_i  (op != SOP_IDLE),
         .upd_val_i (sp_next[h*BYTE_W +: BYTE_W]),
         .q_o       (sp_q[h*BYTE_W +: BYTE_W])
      );
   end

   assign io_rdata_lo = sp_q[BYTE_W-1:0];
   assign io_rdata_hi = sp_q[ADDR_W-1:BYTE_W];
endmodule

// File: rtl/stkp_chk.sv
module stkp_chk #(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned TOP_ADDR = 32'h0000_04FF
) (
   input logic                clk,
   input logic                rst_n,
   input logic                io_wr_lo,
   input logic                io_wr_hi,
   input logic [BYTE_W-1:0]   io_wdata,
   input logic [BYTE_W-1:0]   io_rdata_lo,
   input logic [BYTE_W-1:0]   io_rdata_hi,
   input logic                op_push,
   input logic                op_pop,
   input logic                op_call,
   input logic                op_ret,
   input logic [2*BYTE_W-1:0] stk_addr_a,
   input logic [2*BYTE_W-1:0] stk_addr_b
);
   localparam int unsigned       AW    = 2 * BYTE_W;
   localparam logic [AW-1:0]     TOP_V = AW'(TOP_ADDR);

   logic [AW-1:0] sp;
   logic          no_wr;
   assign sp    = {io_rdata_hi, io_rdata_lo};
   assign no_wr = !io_wr_lo && !io_wr_hi;

   // R1
   reset_value_chk: assert property (@(posedge clk)
      !rst_n |=> sp == TOP_V);

   // R2
   push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_push && !op_call && !op_ret && no_wr) |=> sp == $past(sp) - AW'(1));

   // R3
   pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_pop && !op_push && !op_call && !op_ret && no_wr) |=> sp == $past(sp) + AW'(1));

   // R4
   call_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_call && no_wr) |=> sp == $past(sp) - AW'(2));

   // R4
   call_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_call && no_wr) |-> (stk_addr_a == sp && stk_addr_b == sp - AW'(1)));

   // R5
   ret_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_ret && !op_call && no_wr) |=> sp == $past(sp) + AW'(2));

   // R7
   low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr_lo && !io_wr_hi) |=> (io_rdata_lo == $past(io_wdata) && $stable(io_rdata_hi)));

   // R8
   write_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !no_wr |-> (stk_addr_a == sp && stk_addr_b == sp));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (no_wr && !op_push && !op_pop && !op_call && !op_ret) |=> $stable(sp));
endmodule

bind stack_ptr_unit stkp_chk #(.BYTE_W(BYTE_W), .TOP_ADDR(TOP_ADDR)) u_stkp_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .io_wr_lo    (io_wr_lo),
   .io_wr_hi    (io_wr_hi),
   .io_wdata    (io_wdata),
   .io_rdata_lo (io_rdata_lo),
   .io_rdata_hi (io_rdata_hi),
   .op_push     (op_push),
   .op_pop      (op_pop),
   .op_call     (op_call),
   .op_ret      (op_ret),
   .stk_addr_a  (stk_addr_a),
   .stk_addr_b  (stk_addr_b)
);

// File: tb/test_stack_ptr_unit.sv
module test_stack_ptr_unit;
   localparam int unsigned BW  = 8;
   localparam int unsigned AW  = 16;
   localparam int unsigned TOP = 32'h0000_08FF;
   localparam int          NV  = 18;
   // vector: wr_lo, wr_hi, wdata, {push,pop,call,ret}, exp_a, exp_b, exp_sp_after
   localparam int          VW  = 1 + 1 + 8 + 4 + 48;

   localparam logic [VW-1:0] VEC [NV] = '{
      {1'b0, 1'b0, 8'h00, 4'b1000, 16'h08FF, 16'h08FF, 16'h08FE}, // R2
      {1'b0, 1'b0, 8'h00, 4'b1000, 16'h08FE, 16'h08FE, 16'h08FD}, // R2
      {1'b0, 1'b0, 8'h00, 4'b0100, 16'h08FE, 16'h08FE, 16'h08FE}, // R3
      {1'b0, 1'b0, 8'h00, 4'b0010, 16'h08FE, 16'h08FD, 16'h08FC}, // R4
      {1'b0, 1'b0, 8'h00, 4'b0001, 16'h08FD, 16'h08FE, 16'h08FE}, // R5
      {1'b0, 1'b0, 8'h00, 4'b0000, 16'h08FE, 16'h08FE, 16'h08FE}, // R10
      {1'b1, 1'b0, 8'h34, 4'b0000, 16'h08FE, 16'h08FE, 16'h0834}, // R7
      {1'b0, 1'b1, 8'h12, 4'b1000, 16'h0834, 16'h0834, 16'h1234}, // R8
      {1'b0, 1'b0, 8'h00, 4'b1010, 16'h1234, 16'h1233, 16'h1232}, // R9
      {1'b0, 1'b0, 8'h00, 4'b0101, 16'h1233, 16'h1234, 16'h1234}, // R9
      {1'b0, 1'b0, 8'h00, 4'b1100, 16'h1234, 16'h1234, 16'h1233}, // R9
      {1'b1, 1'b0, 8'hFF, 4'b0110, 16'h1233, 16'h1233, 16'h12FF}, // R8
      {1'b0, 1'b1, 8'hFF, 4'b0000, 16'h12FF, 16'h12FF, 16'hFFFF}, // R7
      {1'b0, 1'b0, 8'h00, 4'b0100, 16'h0000, 16'h0000, 16'h0000}, // R6
      {1'b0, 1'b0, 8'h00, 4'b1000, 16'h0000, 16'h0000, 16'hFFFF}, // R6
      {1'b0, 1'b0, 8'h00, 4'b0001, 16'h0000, 16'h0001, 16'h0001}, // R6
      {1'b0, 1'b0, 8'h00, 4'b0010, 16'h0001, 16'h0000, 16'hFFFF}, // R6
      {1'b1, 1'b1, 8'h55, 4'b0000, 16'hFFFF, 16'hFFFF, 16'h5555}  // R7
   };
   localparam string TAG [NV] = '{"R2","R2","R3","R4","R5","R10","R7","R8","R9",
                                  "R9","R9","R8","R7","R6","R6","R6","R6","R7"};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          io_wr_lo = 1'b0, io_wr_hi = 1'b0;
   logic [BW-1:0] io_wdata = '0;
   logic [BW-1:0] io_rdata_lo, io_rdata_hi;
   logic          op_push = 1'b0, op_pop = 1'b0, op_call = 1'b0, op_ret = 1'b0;
   logic [AW-1:0] stk_addr_a, stk_addr_b;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   stack_ptr_unit #(.BYTE_W(BW), .TOP_ADDR(TOP)) i_stack_ptr_unit (
      .clk(clk), .rst_n(rst_n),
      .io_wr_lo(io_wr_lo), .io_wr_hi(io_wr_hi), .io_wdata(io_wdata),
      .io_rdata_lo(io_rdata_lo), .io_rdata_hi(io_rdata_hi),
      .op_push(op_push), .op_pop(op_pop), .op_call(op_call), .op_ret(op_ret),
      .stk_addr_a(stk_addr_a), .stk_addr_b(stk_addr_b)
   );

   task automatic check(input string req, input string what,
                        input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic wl, input logic wh, input logic [7:0] wd,
                        input logic [3:0] ops);
      io_wr_lo = wl; io_wr_hi = wh; io_wdata = wd;
      {op_push, op_pop, op_call, op_ret} = ops;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below 5000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
         end
      end
   end

   initial begin
      // R1: held in reset while strobes are active
      drive(1'b0, 1'b0, 8'h00, 4'b1010);
      repeat (3) @(negedge clk);
      check("R1", "reset value", {io_rdata_hi, io_rdata_lo}, AW'(TOP));
      drive(1'b1, 1'b1, 8'hAA, 4'b0000);
      @(posedge clk); #1;
      check("R1", "reset ignores write", {io_rdata_hi, io_rdata_lo}, AW'(TOP));
      @(negedge clk);
      drive(1'b0, 1'b0, 8'h00, 4'b0000);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         @(negedge clk);
         drive(v[61], v[60], v[59:52], v[51:48]);
         #1;
         check(TAG[i], "addr_a", stk_addr_a, v[47:32]);
         check(TAG[i], "addr_b", stk_addr_b, v[31:16]);
         @(posedge clk); #1;
         check(TAG[i], "pointer", {io_rdata_hi, io_rdata_lo}, v[15:0]);
      end

      // R1: reset asserted mid-run restores the top address
      @(negedge clk);
      drive(1'b0, 1'b0, 8'h00, 4'b1000);
      rst_n = 1'b0;
      #1;
      check("R1", "async reset", {io_rdata_hi, io_rdata_lo}, AW'(TOP));
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 8'h00, 4'b0000);
      @(posedge clk); #1;
      check("R10", "hold after reset", {io_rdata_hi, io_rdata_lo}, AW'(TOP));

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule